// File: doc/BRIEF.md
# UDP Receive Packet Router

This block sorts incoming UDP datagrams onto an on-chip bus. Software first loads a small receiver table with configuration commands. Each command names a remote sender by its source IP address, its source port and the local destination port, and gives a bus address where that sender's payload should go. The block answers each command with an acknowledge written to that bus address. The acknowledge is negative when the table has no free slot left.

For each datagram the UDP side offers a header: a strobe, the byte length, the source IP, both ports and an error flag. The first 16-bit payload halfword comes with the header. The block compares the header against every table slot in the same cycle. If one slot matches and the error flag is clear, the block writes the slot's target address onto the bus and then the payload, packed two halfwords per 32-bit word. Any other datagram is read to its end and thrown away, so the stream stays aligned for the next header.

The configuration engine has the states CFG_IDLE, CFG_IP, CFG_PORTS, CFG_TGT, CFG_ACK_ADDR and CFG_ACK_DATA. It moves forward one state per accepted word, then one state per completed bus write, and returns to CFG_IDLE. The receive engine has the states RX_IDLE, RX_ADDR, RX_HI, RX_LO, RX_WR and RX_DRAIN:
- RX_IDLE goes to RX_ADDR on a header that hits, or to RX_DRAIN on a rejected header that has more than one halfword.
- RX_ADDR goes to RX_HI, or to RX_WR when the datagram is a single halfword.
- RX_HI goes to RX_WR.
- RX_WR goes back to RX_IDLE after the last word, and otherwise to RX_LO.
- RX_LO goes to RX_HI, or to RX_WR when it has just read the last halfword.
- RX_DRAIN goes back to RX_IDLE after the last halfword.

Top module: `udp_rx_router`

## Requirements
- R1: A configuration command is four words: an opener whose bits [31:28] equal 0x3, the source IP, a ports word (destination port in [31:16], source port in [15:0]) and the target bus address. In the idle state, any word with a different top nibble is accepted (`cfg_ready` high) and has no effect.
- R2: After a command, two bus writes go out back to back. The first has `bus_av`=1 and carries the target address. The second has `bus_av`=0 and carries 0x50 in [31:24] and the slot index in its low bits. Slots fill in order from 0.
- R3: When all slots (4 by default) are in use, a command changes no slot and its second word is 0x51000000. A slot is never released.
- R4: A datagram hits a slot only if its source IP, source port and destination port all equal that slot's values. If several slots hit, the lowest index wins.
- R5: A datagram whose error flag is set is never forwarded, even when it hits a slot.
- R6: A datagram that is not forwarded is read for exactly ceil(len/2) halfwords, where a length of 0 counts as one halfword. It causes no bus write.
- R7: A forwarded datagram first produces one write with `bus_av`=1 carrying the slot's target. It then produces ceil(ceil(len/2)/2) writes with `bus_av`=0. Each data word holds the earlier halfword in [15:0] and the later one in [31:16]. A trailing odd halfword has zero in [31:16].
- R8: A halfword is taken only in a cycle where both `rx_re` and `rx_valid` are high. The first halfword is taken together with the header (`new_rx` high). In the idle state `rx_re` is low while `new_rx` is low.
- R9: While `bus_full` is high, a pending write keeps `bus_we` high and holds `bus_data` and `bus_av` steady. The write completes on the first cycle in which `bus_full` is low.
- R10: A 1-byte datagram followed at once by another datagram loses neither of them.
- R11: After reset the table is empty, `bus_we` and `rx_re` are low, and `cfg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_data | input | 32 | Configuration word |
| cfg_ready | output | 1 | Configuration word accepted this cycle when valid |
| new_rx | input | 1 | Header present with the first halfword |
| rx_len | input | LEN_W | Datagram length in bytes |
| rx_src_ip | input | 32 | Sender IP address |
| rx_src_port | input | 16 | Sender UDP port |
| rx_dst_port | input | 16 | Local UDP port |
| rx_err | input | 1 | Datagram flagged as damaged |
| rx_data | input | 16 | Payload halfword |
| rx_valid | input | 1 | Halfword present |
| rx_re | output | 1 | Read enable toward the UDP side |
| bus_we | output | 1 | Bus write request |
| bus_av | output | 1 | The word on bus_data is an address |
| bus_data | output | 32 | Bus write word |
| bus_full | input | 1 | Bus cannot take a word this cycle |

## Verification
The hardest situation to reach is a rejected datagram whose drain length is off by one. Nothing reaches the bus in that case, so the fault stays hidden until the next header. The stimulus therefore sends every rejected datagram, for lengths 0 to 6, immediately followed by a matching datagram, and checks that the second one arrives intact. The same back-to-back pattern, with the bus stalling on two cycles out of three, covers a 1-byte datagram followed by a longer one.

// File: rtl/udprr_pkg.sv
package udprr_pkg;
    localparam int BUS_W  = 32;
    localparam int HW_W   = 16;
    localparam int IP_W   = 32;
    localparam int PORT_W = 16;

    localparam logic [3:0] CFG_OPC = 4'h3;
    localparam logic [7:0] ACK_OK  = 8'h50;
    localparam logic [7:0] ACK_NAK = 8'h51;

    typedef enum logic [2:0] {
        CFG_IDLE,
        CFG_IP,
        CFG_PORTS,
        CFG_TGT,
        CFG_ACK_ADDR,
        CFG_ACK_DATA
    } cfg_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_HI,
        RX_LO,
        RX_WR,
        RX_DRAIN
    } rx_state_t;

    typedef struct packed {
        logic [IP_W-1:0]   ip;
        logic [PORT_W-1:0] sport;
        logic [PORT_W-1:0] dport;
        logic [BUS_W-1:0]  tgt;
    } rx_entry_t;
endpackage

// File: rtl/udprr_table.sv
module udprr_table
    import udprr_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  rx_entry_t         wr_entry,
    input  logic [IP_W-1:0]   lk_ip,
    input  logic [PORT_W-1:0] lk_sport,
    input  logic [PORT_W-1:0] lk_dport,
    output logic              hit,
    output logic [BUS_W-1:0]  hit_tgt,
    output logic              full,
    output logic [IDX_W-1:0]  free_idx,
    output logic [DEPTH-1:0]  valid_o
);
    rx_entry_t        ent_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && !full && free_idx == IDX_W'(g)) begin
                ent_q[g] <= wr_entry;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
            end else if (wr_en && !full && free_idx == IDX_W'(g)) begin
                vld_q[g] <= 1'b1;
            end
        end

        assign eq[g] = vld_q[g]
                    && ent_q[g].ip    == lk_ip
                    && ent_q[g].sport == lk_sport
                    && ent_q[g].dport == lk_dport;
    end

    always_comb begin
        hit     = 1'b0;
        hit_tgt = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_tgt = ent_q[i].tgt;
            end
        end
    end

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign full    = &vld_q;
    assign valid_o = vld_q;
endmodule

// File: rtl/udprr_cfg.sv
module udprr_cfg
    import udprr_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [BUS_W-1:0] cfg_data,
    output logic             cfg_ready,
    input  logic             tbl_full,
    input  logic [IDX_W-1:0] tbl_free_idx,
    output logic             tbl_wr_en,
    output rx_entry_t        tbl_wr_entry,
    output logic             ack_req,
    output logic             ack_av,
    output logic [BUS_W-1:0] ack_data,
    input  logic             ack_done
);
    cfg_state_t       st_q, st_d;
    logic [IP_W-1:0]  ip_q;
    logic [BUS_W-1:0] ports_q;
    logic [BUS_W-1:0] tgt_q;
    logic             ok_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CFG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        cfg_ready = 1'b0;
        tbl_wr_en = 1'b0;
        ack_req   = 1'b0;
        ack_av    = 1'b0;
        ack_data  = '0;
        unique case (st_q)
            CFG_IDLE: begin
                cfg_ready = 1'b1;
                if (cfg_valid && cfg_data[31:28] == CFG_OPC) begin
                    st_d = CFG_IP;
                end
            end
            CFG_IP: begin
                cfg_ready = 1'b1;
                if (cfg_valid) begin
                    st_d = CFG_PORTS;
                end
            end
            CFG_PORTS: begin
                cfg_ready = 1'b1;
                if (cfg_valid) begin
                    st_d = CFG_TGT;
                end
            end
            CFG_TGT: begin
                cfg_ready = 1'b1;
                if (cfg_valid) begin
                    tbl_wr_en = !tbl_full;
                    st_d      = CFG_ACK_ADDR;
                end
            end
            CFG_ACK_ADDR: begin
                ack_req  = 1'b1;
                ack_av   = 1'b1;
                ack_data = tgt_q;
                if (ack_done) begin
                    st_d = CFG_ACK_DATA;
                end
            end
            CFG_ACK_DATA: begin
                ack_req  = 1'b1;
                ack_data = ok_q ? {ACK_OK, {(24 - IDX_W){1'b0}}, idx_q}
                                : {ACK_NAK, 24'h0};
                if (ack_done) begin
                    st_d = CFG_IDLE;
                end
            end
            default: st_d = CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q    <= '0;
            ports_q <= '0;
            tgt_q   <= '0;
            ok_q    <= 1'b0;
            idx_q   <= '0;
        end else if (cfg_valid) begin
            if (st_q == CFG_IP) begin
                ip_q <= cfg_data;
            end
            if (st_q == CFG_PORTS) begin
                ports_q <= cfg_data;
            end
            if (st_q == CFG_TGT) begin
                tgt_q <= cfg_data;
                ok_q  <= !tbl_full;
                idx_q <= tbl_free_idx;
            end
        end
    end

    assign tbl_wr_entry = '{ip: ip_q, sport: ports_q[15:0],
                            dport: ports_q[31:16], tgt: cfg_data};
endmodule

// File: rtl/udprr_rx.sv
module udprr_rx
    import udprr_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             new_rx,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             rx_err,
    input  logic [HW_W-1:0]  rx_data,
    input  logic             rx_valid,
    output logic             rx_re,
    input  logic             hit,
    input  logic [BUS_W-1:0] hit_tgt,
    output logic             wr_req,
    output logic             wr_av,
    output logic [BUS_W-1:0] wr_data,
    input  logic             wr_done,
    output logic             bus_free,
    output logic             idle
);
    rx_state_t        st_q, st_d;
    logic [LEN_W-1:0] rem_q;
    logic [HW_W-1:0]  lo_q, hi_q;
    logic [BUS_W-1:0] tgt_q;
    logic [LEN_W:0]   len_p1;
    logic [LEN_W-1:0] total;
    logic [LEN_W-1:0] first_rem;
    logic             take;

    assign len_p1    = {1'b0, rx_len} + (LEN_W + 1)'(1);
    assign total     = len_p1[LEN_W:1];
    assign first_rem = (total == '0) ? '0 : total - LEN_W'(1);
    assign take      = rx_re && rx_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        rx_re   = 1'b0;
        wr_req  = 1'b0;
        wr_av   = 1'b0;
        wr_data = '0;
        unique case (st_q)
            RX_IDLE: begin
                rx_re = new_rx && !hold;
                if (take) begin
                    if (hit && !rx_err) begin
                        st_d = RX_ADDR;
                    end else if (first_rem != '0) begin
                        st_d = RX_DRAIN;
                    end
                end
            end
            RX_ADDR: begin
                wr_req  = 1'b1;
                wr_av   = 1'b1;
                wr_data = tgt_q;
                if (wr_done) begin
                    st_d = (rem_q == '0) ? RX_WR : RX_HI;
                end
            end
            RX_HI: begin
                rx_re = 1'b1;
                if (rx_valid) begin
                    st_d = RX_WR;
                end
            end
            RX_WR: begin
                wr_req  = 1'b1;
                wr_data = {hi_q, lo_q};
                if (wr_done) begin
                    st_d = (rem_q == '0) ? RX_IDLE : RX_LO;
                end
            end
            RX_LO: begin
                rx_re = 1'b1;
                if (rx_valid) begin
                    st_d = (rem_q == LEN_W'(1)) ? RX_WR : RX_HI;
                end
            end
            RX_DRAIN: begin
                rx_re = 1'b1;
                if (rx_valid && rem_q == LEN_W'(1)) begin
                    st_d = RX_IDLE;
                end
            end
            default: st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            tgt_q <= '0;
        end else begin
            unique case (st_q)
                RX_IDLE: begin
                    if (take) begin
                        lo_q  <= rx_data;
                        hi_q  <= '0;
                        rem_q <= first_rem;
                        tgt_q <= hit_tgt;
                    end
                end
                RX_HI: begin
                    if (rx_valid) begin
                        hi_q  <= rx_data;
                        rem_q <= rem_q - LEN_W'(1);
                    end
                end
                RX_LO: begin
                    if (rx_valid) begin
                        lo_q  <= rx_data;
                        hi_q  <= '0;
                        rem_q <= rem_q - LEN_W'(1);
                    end
                end
                RX_DRAIN: begin
                    if (rx_valid) begin
                        rem_q <= rem_q - LEN_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign bus_free = (st_q == RX_IDLE) || (st_q == RX_DRAIN);
    assign idle     = (st_q == RX_IDLE);
endmodule

// File: rtl/udp_rx_router.sv
module udp_rx_router
    import udprr_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 11,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [BUS_W-1:0]  cfg_data,
    output logic              cfg_ready,
    input  logic              new_rx,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [IP_W-1:0]   rx_src_ip,
    input  logic [PORT_W-1:0] rx_src_port,
    input  logic [PORT_W-1:0] rx_dst_port,
    input  logic              rx_err,
    input  logic [HW_W-1:0]   rx_data,
    input  logic              rx_valid,
    output logic              rx_re,
    output logic              bus_we,
    output logic              bus_av,
    output logic [BUS_W-1:0]  bus_data,
    input  logic              bus_full
);
    logic             tbl_wr_en;
    rx_entry_t        tbl_wr_entry;
    logic             tbl_hit;
    logic [BUS_W-1:0] tbl_hit_tgt;
    logic             tbl_full;
    logic [IDX_W-1:0] tbl_free_idx;
    logic [DEPTH-1:0] tbl_vld;

    logic             ack_req, ack_av, ack_done;
    logic [BUS_W-1:0] ack_data;
    logic             wr_req, wr_av, wr_done;
    logic [BUS_W-1:0] wr_data;
    logic             rx_free, rx_idle;
    logic             cfg_gnt, rx_gnt;

    udprr_table #(.DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_entry (tbl_wr_entry),
        .lk_ip    (rx_src_ip),
        .lk_sport (rx_src_port),
        .lk_dport (rx_dst_port),
        .hit      (tbl_hit),
        .hit_tgt  (tbl_hit_tgt),
        .full     (tbl_full),
        .free_idx (tbl_free_idx),
        .valid_o  (tbl_vld)
    );

    udprr_cfg #(.IDX_W(IDX_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid    (cfg_valid),
        .cfg_data     (cfg_data),
        .cfg_ready    (cfg_ready),
        .tbl_full     (tbl_full),
        .tbl_free_idx (tbl_free_idx),
        .tbl_wr_en    (tbl_wr_en),
        .tbl_wr_entry (tbl_wr_entry),
        .ack_req      (ack_req),
        .ack_av       (ack_av),
        .ack_data     (ack_data),
        .ack_done     (ack_done)
    );

    udprr_rx #(.LEN_W(LEN_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (ack_req),
        .new_rx   (new_rx),
        .rx_len   (rx_len),
        .rx_err   (rx_err),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_re    (rx_re),
        .hit      (tbl_hit),
        .hit_tgt  (tbl_hit_tgt),
        .wr_req   (wr_req),
        .wr_av    (wr_av),
        .wr_data  (wr_data),
        .wr_done  (wr_done),
        .bus_free (rx_free),
        .idle     (rx_idle)
    );

    // The acknowledge pair only starts between forwarded datagrams, and a
    // pending acknowledge keeps new headers out, so neither stream splits.
    assign cfg_gnt  = ack_req && rx_free;
    assign rx_gnt   = wr_req && !cfg_gnt;
    assign ack_done = cfg_gnt && !bus_full;
    assign wr_done  = rx_gnt && !bus_full;

    assign bus_we   = cfg_gnt || rx_gnt;
    assign bus_av   = cfg_gnt ? ack_av : wr_av;
    assign bus_data = cfg_gnt ? ack_data : wr_data;
endmodule

// File: rtl/udprr_chk.sv
module udprr_chk #(
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             bus_full,
    input logic             bus_av,
    input logic [31:0]      bus_data,
    input logic             rx_re,
    input logic             rx_valid,
    input logic             new_rx,
    input logic             cfg_gnt,
    input logic             rx_idle,
    input logic [DEPTH-1:0] tbl_vld
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_full |=> bus_we && $stable(bus_data) && $stable(bus_av)); // R9

    AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !bus_full && bus_av |=> !(bus_we && !bus_full && bus_av)); // R7

    AST_TABLE_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(tbl_vld) >= $past($countones(tbl_vld))); // R3

    AST_ACK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_gnt && !bus_av |-> bus_data[31:24] == 8'h50 || bus_data[31:24] == 8'h51); // R2

    AST_TAKE_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_re && rx_valid && !new_rx |-> !rx_idle); // R8
endmodule

bind udp_rx_router udprr_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_full (bus_full),
    .bus_av   (bus_av),
    .bus_data (bus_data),
    .rx_re    (rx_re),
    .rx_valid (rx_valid),
    .new_rx   (new_rx),
    .cfg_gnt  (cfg_gnt),
    .rx_idle  (rx_idle),
    .tbl_vld  (tbl_vld)
);

// File: tb/udp_rx_router_tb.sv
module udp_rx_router_tb;
    localparam int DEPTH = 4;
    localparam int LEN_W = 11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             cfg_valid = 1'b0;
    logic [31:0]      cfg_data = '0;
    logic             cfg_ready;
    logic             new_rx = 1'b0;
    logic [LEN_W-1:0] rx_len = '0;
    logic [31:0]      rx_src_ip = '0;
    logic [15:0]      rx_src_port = '0;
    logic [15:0]      rx_dst_port = '0;
    logic             rx_err = 1'b0;
    logic [15:0]      rx_data = '0;
    logic             rx_valid = 1'b0;
    logic             rx_re;
    logic             bus_we;
    logic             bus_av;
    logic [31:0]      bus_data;
    logic             bus_full = 1'b0;

    udp_rx_router #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (
        .clk, .rst_n, .cfg_valid, .cfg_data, .cfg_ready,
        .new_rx, .rx_len, .rx_src_ip, .rx_src_port, .rx_dst_port,
        .rx_err, .rx_data, .rx_valid, .rx_re,
        .bus_we, .bus_av, .bus_data, .bus_full
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit stall_en = 0;
    int cyc = 0;
    logic [31:0] q_data[$];
    logic        q_av[$];
    logic [31:0] e_data[$];
    logic        e_av[$];

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ip_of(int e);
        return 32'hC0A8_0000 + e;
    endfunction
    function automatic logic [15:0] sp_of(int e);
        return 16'h1000 + 16'(e);
    endfunction
    function automatic logic [15:0] dp_of(int e);
        return 16'h2000 + 16'(e);
    endfunction
    function automatic logic [31:0] tgt_of(int e);
        return 32'hA000_0000 + 32'(e * 16);
    endfunction
    function automatic logic [15:0] hw(int p, int i);
        return {p[7:0], i[7:0]};
    endfunction

    // Bus sink: records completed writes and checks the stall hold (R9)
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    logic        prev_av = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            bus_full = stall_en && ((cyc % 3) != 0);
            #2;
            if (prev_stall) begin
                chk(bus_we && bus_data == prev_data && bus_av == prev_av,
                    "R9", bus_data, prev_data);
            end
            prev_stall = bus_we && bus_full;
            prev_data  = bus_data;
            prev_av    = bus_av;
            if (bus_we && !bus_full) begin
                q_data.push_back(bus_data);
                q_av.push_back(bus_av);
            end
        end
    end

    task automatic send_cfg_word(logic [31:0] w);
        bit ok;
        cfg_valid = 1'b1;
        cfg_data  = w;
        do begin
            #1;
            ok = cfg_ready;
            @(negedge clk);
        end while (!ok);
        cfg_valid = 1'b0;
    endtask

    task automatic send_cfg(logic [31:0] ip, logic [15:0] sp, logic [15:0] dp,
                            logic [31:0] tgt);
        send_cfg_word(32'h3000_0000);
        send_cfg_word(ip);
        send_cfg_word({dp, sp});
        send_cfg_word(tgt);
    endtask

    task automatic send_pkt(logic [31:0] ip, logic [15:0] sp, logic [15:0] dp,
                            bit err, int len, int p, int gap);
        int nhw;
        bit ok;
        nhw = (len == 0) ? 1 : (len + 1) / 2;
        for (int i = 0; i < nhw; i++) begin
            new_rx      = (i == 0);
            rx_len      = LEN_W'(len);
            rx_src_ip   = ip;
            rx_src_port = sp;
            rx_dst_port = dp;
            rx_err      = err;
            rx_valid    = 1'b1;
            rx_data     = hw(p, i);
            do begin
                #1;
                ok = rx_re;
                @(negedge clk);
            end while (!ok);
            new_rx   = 1'b0;
            rx_valid = 1'b0;
            if (gap > 0) repeat (gap) @(negedge clk);
        end
    endtask

    task automatic expect_pkt(int e, int p, int len);
        int nhw;
        nhw = (len + 1) / 2;
        e_data.push_back(tgt_of(e));
        e_av.push_back(1'b1);
        for (int j = 0; j < nhw; j += 2) begin
            e_data.push_back({(j + 1 < nhw) ? hw(p, j + 1) : 16'h0, hw(p, j)});
            e_av.push_back(1'b0);
        end
    endtask

    task automatic compare(string req);
        int n;
        repeat (40) @(negedge clk);
        chk(q_data.size() == e_data.size(), req, 32'(q_data.size()), 32'(e_data.size()));
        n = (q_data.size() < e_data.size()) ? q_data.size() : e_data.size();
        for (int i = 0; i < n; i++) begin
            chk(q_data[i] == e_data[i] && q_av[i] == e_av[i], req,
                {q_av[i], q_data[i][30:0]}, {e_av[i], e_data[i][30:0]});
        end
        q_data.delete(); q_av.delete(); e_data.delete(); e_av.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int p;
        p = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: idle outputs after reset
        chk(rx_re == 1'b0, "R11", 32'(rx_re), 32'h0);
        chk(bus_we == 1'b0, "R11", 32'(bus_we), 32'h0);
        chk(cfg_ready == 1'b1, "R11", 32'(cfg_ready), 32'h1);
        @(negedge clk);

        // R1: stray words in idle are taken and ignored
        send_cfg_word(32'h1234_5678);
        send_cfg_word(32'h4000_0001);
        #1;
        chk(cfg_ready == 1'b1, "R1", 32'(cfg_ready), 32'h1);
        @(negedge clk);
        compare("R1");

        // R2: fill every slot, acknowledge carries 0x50 and the slot index
        for (int e = 0; e < DEPTH; e++) begin
            send_cfg(ip_of(e), sp_of(e), dp_of(e), tgt_of(e));
            e_data.push_back(tgt_of(e)); e_av.push_back(1'b1);
            e_data.push_back(32'h5000_0000 | 32'(e)); e_av.push_back(1'b0);
            compare("R2");
        end

        // R3: full table refuses with 0x51 and stores nothing
        send_cfg(32'hDEAD_BEEF, 16'h1111, 16'h2222, 32'hB000_0000);
        e_data.push_back(32'hB000_0000); e_av.push_back(1'b1);
        e_data.push_back(32'h5100_0000); e_av.push_back(1'b0);
        compare("R3");
        send_pkt(32'hDEAD_BEEF, 16'h1111, 16'h2222, 1'b0, 4, p, 0);
        p++;
        compare("R3");

        // R7 / R8 / R9: sweep slots and lengths, with and without bus stalls
        for (int s = 0; s < 2; s++) begin
            stall_en = (s == 1);
            for (int e = 0; e < DEPTH; e++) begin
                for (int len = 1; len <= 8; len++) begin
                    #1;
                    chk(rx_re == 1'b0, "R8", 32'(rx_re), 32'h0);
                    @(negedge clk);
                    send_pkt(ip_of(e), sp_of(e), dp_of(e), 1'b0, len, p, len % 2);
                    expect_pkt(e, p, len);
                    p++;
                    compare(s == 1 ? "R9" : "R7");
                end
            end
        end
        stall_en = 0;

        // R4: one mismatching field is enough to drop
        for (int e = 0; e < DEPTH; e++) begin
            send_pkt(ip_of(e) ^ 32'h100, sp_of(e), dp_of(e), 1'b0, 4, p, 0); p++;
            send_pkt(ip_of(e), sp_of((e + 1) % DEPTH), dp_of(e), 1'b0, 4, p, 0); p++;
            send_pkt(ip_of(e), sp_of(e), dp_of((e + 1) % DEPTH), 1'b0, 4, p, 0); p++;
            compare("R4");
        end

        // R5: error flag drops a matching datagram
        for (int e = 0; e < DEPTH; e++) begin
            send_pkt(ip_of(e), sp_of(e), dp_of(e), 1'b1, 6, p, 0); p++;
            compare("R5");
        end

        // R6: drained length is exact; the next datagram follows at once
        for (int len = 0; len <= 6; len++) begin
            send_pkt(ip_of(1), sp_of(2), dp_of(3), 1'b0, len, p, 0); p++;
            send_pkt(ip_of(2), sp_of(2), dp_of(2), 1'b0, 3, p, 0);
            expect_pkt(2, p, 3); p++;
            compare("R6");
        end

        // R10: 1-byte datagram then another, back to back under stalls
        stall_en = 1;
        send_pkt(ip_of(0), sp_of(0), dp_of(0), 1'b0, 1, p, 0);
        expect_pkt(0, p, 1); p++;
        send_pkt(ip_of(1), sp_of(1), dp_of(1), 1'b0, 5, p, 0);
        expect_pkt(1, p, 5); p++;
        compare("R10");
        stall_en = 0;

        // R3: original slots still intact after the refused command
        send_pkt(ip_of(3), sp_of(3), dp_of(3), 1'b0, 2, p, 0);
        expect_pkt(3, p, 2); p++;
        compare("R3");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule